// File: doc/BRIEF.md
# Nibble Command Register Bridge

This block terminates a byte-wide host stream, for example the receive side of a FIFO behind a USB bridge, and turns it into accesses to a small local register file. Each incoming byte carries an operation code in bits [7:4] and four payload bits in bits [3:0]. An 8-bit register pointer and an 8-bit write value are each built from two such bytes, with the low half first. Reads place one byte on an outgoing byte stream.

The host loads the pointer with two bytes, then sends pairs of data bytes. The second byte of each pair commits the write and moves the pointer on, so a burst can fill several neighbouring registers. Reads return the register under the pointer. One read variant also steps the pointer, so a run of such reads streams out a multi-byte value, least significant byte first. Both sides use valid/ready handshakes. While a read byte is still waiting to be taken, the input is held off.

Top module: `nibble_reg_bridge`

## Requirements
- R1: A synchronous reset clears the pointer, the low-data latch and all registers to 0x00, and drops outValid; inReady is high after reset.
- R2: Code 0x0 loads pointer bits [3:0] from the payload and code 0x1 loads pointer bits [7:4]; the other half of the pointer is kept.
- R3: Code 0x2 stores the payload as the low data half. Code 0x3 writes {payload, low half} to the register under the pointer, then adds one to the pointer, wrapping from 0xFF to 0x00.
- R4: Code 0x4 puts the register under the pointer on outByte with outValid high from the cycle after acceptance; the pointer does not change.
- R5: Code 0x5 returns a byte as code 0x4 does, then adds one to the pointer.
- R6: Pointer values at or above the register count (16) give 0x00 on reads and discard writes, though the write still steps the pointer.
- R7: Codes 0x6 to 0xF are accepted and ignored: pointer, latch and registers keep their values and no byte is produced.
- R8: While outValid is high, inReady is low and outByte holds. outValid drops in the cycle after outReady is seen high.
- R9: A value written as a burst of bytes to neighbouring registers comes back unchanged from the same number of stepping reads, lowest register first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByte | input | 8 | Command byte: code in [7:4], payload in [3:0] |
| inValid | input | 1 | inByte is valid |
| inReady | output | 1 | Block can accept a command byte |
| outByte | output | 8 | Read-back byte |
| outValid | output | 1 | outByte is valid |
| outReady | input | 1 | Consumer takes outByte |

## Verification
The bench aims at pointer arithmetic: it sets the two halves of the pointer separately, steps past the end of the register file, and wraps from 0xFF to 0x00. A design that mixed up the halves, failed to wrap, or aliased out-of-range addresses onto real registers would return a wrong byte or corrupt a register. Ignored codes sent between a low and a high data nibble expose a decoder that lets them touch the latch. A write held on the input while a read byte is pending must wait and then land exactly once; a bridge that accepted it early or dropped it would write the wrong value.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  localparam int NIB_W  = 4;
  localparam int DATA_W = 2 * NIB_W;
  localparam int ADDR_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    CMD_PTR_LO   = 4'h0,
    CMD_PTR_HI   = 4'h1,
    CMD_DAT_LO   = 4'h2,
    CMD_DAT_HI   = 4'h3,
    CMD_RD       = 4'h4,
    CMD_RD_STEP  = 4'h5
  } cmd_e;

  typedef struct packed {
    logic             setPtrLo;
    logic             setPtrHi;
    logic             setDatLo;
    logic             commitWrite;
    logic             loadRead;
    logic             stepPtr;
    logic [NIB_W-1:0] nib;
  } strobe_t;
endpackage

// File: rtl/nrb_ctrl.sv
module nrb_ctrl
  import nrb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inByte,
  input  logic              inValid,
  output logic              inReady,
  input  logic              outReady,
  output logic              outValid,
  output strobe_t           stb
);
  logic outValidQ;
  logic accept;
  cmd_e code;

  assign inReady  = !outValidQ;
  assign outValid = outValidQ;
  assign accept   = inValid && inReady;
  assign code     = cmd_e'(inByte[DATA_W-1:NIB_W]);

  always_comb begin
    stb     = '0;
    stb.nib = inByte[NIB_W-1:0];
    if (accept) begin
      case (code)
        CMD_PTR_LO:  stb.setPtrLo    = 1'b1;
        CMD_PTR_HI:  stb.setPtrHi    = 1'b1;
        CMD_DAT_LO:  stb.setDatLo    = 1'b1;
        CMD_DAT_HI:  stb.commitWrite = 1'b1;
        CMD_RD:      stb.loadRead    = 1'b1;
        CMD_RD_STEP: begin
          stb.loadRead = 1'b1;
          stb.stepPtr  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               outValidQ <= 1'b0;
    else if (stb.loadRead) outValidQ <= 1'b1;
    else if (outReady)     outValidQ <= 1'b0;
  end

  // R4: an accepted read raises outValid on the next cycle
  assert_read_raises_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inByte[DATA_W-1:NIB_W] inside {4'h4, 4'h5}) |=> outValid);

  // R7: an ignored code produces no output byte
  assert_ignored_code_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady && inByte[DATA_W-1:NIB_W] > 4'h5) |=> !outValid);

  // R8: no command takes effect while a byte waits
  assert_no_strobe_when_waiting_R8: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !(stb.setPtrLo || stb.setPtrHi || stb.setDatLo || stb.commitWrite || stb.loadRead));

  // R8: outValid drops after the consumer takes the byte
  assert_drop_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid && outReady) |=> !outValid);
endmodule

// File: rtl/nrb_datapath.sv
module nrb_datapath
  import nrb_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter bit WRITE_STEP = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  output logic [DATA_W-1:0] outByte
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [ADDR_W-1:0] ptr;
  logic [NIB_W-1:0]  datLo;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [IDX_W-1:0]  ptrIdx;
  logic              inRange;
  logic              wrEn;
  logic              stepNow;
  logic [DATA_W-1:0] rdByte;

  assign ptrIdx  = ptr[IDX_W-1:0];
  assign inRange = {1'b0, ptr} < (ADDR_W+1)'(NUM_REGS);
  assign wrEn    = stb.commitWrite && inRange;
  assign rdByte  = inRange ? regs[ptrIdx] : '0;

  generate
    if (WRITE_STEP) begin : g_write_steps
      assign stepNow = stb.stepPtr || stb.commitWrite;
    end else begin : g_write_holds
      assign stepNow = stb.stepPtr;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      datLo <= '0;
    end else begin
      if (stb.setPtrLo)      ptr[NIB_W-1:0]      <= stb.nib;
      else if (stb.setPtrHi) ptr[ADDR_W-1:NIB_W] <= stb.nib;
      else if (stepNow)      ptr                 <= ptr + ADDR_W'(1);
      if (stb.setDatLo)      datLo               <= stb.nib;
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REGS; r++) begin
      if (rst)
        regs[r] <= '0;
      else if (wrEn && ptrIdx == IDX_W'(r))
        regs[r] <= {stb.nib, datLo};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               outByte <= '0;
    else if (stb.loadRead) outByte <= rdByte;
  end

  // R2: low pointer load keeps the high half
  assert_ptr_lo_load_R2: assert property (@(posedge clk) disable iff (rst)
    stb.setPtrLo |=> (ptr[ADDR_W-1:NIB_W] == $past(ptr[ADDR_W-1:NIB_W])) && (ptr[NIB_W-1:0] == $past(stb.nib)));

  // R2: high pointer load keeps the low half
  assert_ptr_hi_load_R2: assert property (@(posedge clk) disable iff (rst)
    stb.setPtrHi |=> (ptr[NIB_W-1:0] == $past(ptr[NIB_W-1:0])) && (ptr[ADDR_W-1:NIB_W] == $past(stb.nib)));

  // R3: committed write lands in the addressed register
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    (stb.commitWrite && inRange) |=> regs[$past(ptrIdx)] == $past({stb.nib, datLo}));

  // R5: stepping read advances the pointer by one
  assert_read_step_R5: assert property (@(posedge clk) disable iff (rst)
    stb.stepPtr |=> ptr == $past(ptr) + ADDR_W'(1));

  // R6: out-of-range read returns zero
  assert_oor_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (stb.loadRead && !inRange) |=> outByte == '0);
endmodule

// File: rtl/nibble_reg_bridge.sv
module nibble_reg_bridge
  import nrb_pkg::*;
#(
  parameter int NUM_REGS   = 16,
  parameter bit WRITE_STEP = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] inByte,
  input  logic       inValid,
  output logic       inReady,
  output logic [7:0] outByte,
  output logic       outValid,
  input  logic       outReady
);
  strobe_t stb;

  nrb_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inByte   (inByte),
    .inValid  (inValid),
    .inReady  (inReady),
    .outReady (outReady),
    .outValid (outValid),
    .stb      (stb)
  );

  nrb_datapath #(
    .NUM_REGS   (NUM_REGS),
    .WRITE_STEP (WRITE_STEP)
  ) i_datapath (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .outByte (outByte)
  );

  // R1: reset leaves the output idle and the input open
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!outValid && inReady));

  // R8: a waiting byte stays valid and stable until taken
  assert_hold_until_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outByte)));
endmodule

// File: tb/test_nibble_reg_bridge.sv
module test_nibble_reg_bridge;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] inByte = 8'h00;
  logic       inValid = 1'b0;
  logic       inReady;
  logic [7:0] outByte;
  logic       outValid;
  logic       outReady = 1'b0;

  int totalCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  logic [7:0] mRegs [16];
  logic [7:0] mPtr;
  logic [3:0] mLo;

  always #5 clk = ~clk;

  nibble_reg_bridge i_nibble_reg_bridge (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outByte(outByte), .outValid(outValid), .outReady(outReady)
  );

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead();
    return (mPtr < 8'd16) ? mRegs[mPtr[3:0]] : 8'h00;
  endfunction

  task automatic modelApply(input logic [7:0] b);
    case (b[7:4])
      4'h0: mPtr[3:0] = b[3:0];
      4'h1: mPtr[7:4] = b[3:0];
      4'h2: mLo = b[3:0];
      4'h3: begin
        if (mPtr < 8'd16) mRegs[mPtr[3:0]] = {b[3:0], mLo};
        mPtr = mPtr + 8'd1;
      end
      4'h5: mPtr = mPtr + 8'd1;
      default: ;
    endcase
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inByte  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    modelApply(b);
  endtask

  task automatic getByte(output logic [7:0] b);
    while (!outValid) @(negedge clk);
    b = outByte;
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic readCheck(input logic step, input string req);
    logic [7:0] exp;
    logic [7:0] got;
    exp = modelRead();
    sendByte(step ? 8'h50 : 8'h40);
    getByte(got);
    checkEq(req, {24'h0, got}, {24'h0, exp});
  endtask

  task automatic setPtr(input logic [7:0] a);
    sendByte({4'h0, a[3:0]});
    sendByte({4'h1, a[7:4]});
  endtask

  task automatic writeByte(input logic [7:0] d);
    sendByte({4'h2, d[3:0]});
    sendByte({4'h3, d[7:4]});
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 16; i++) mRegs[i] = 8'h00;
    mPtr = 8'h00;
    mLo  = 4'h0;
    checkEq("R1 outValid after reset", {31'h0, outValid}, 32'h0);
    checkEq("R1 inReady after reset", {31'h0, inReady}, 32'h1);
    for (int i = 0; i < 16; i++) readCheck(1'b1, "R1 register cleared");
    checkEq("R5 pointer stepped to 16", {24'h0, mPtr}, 32'h10);
    readCheck(1'b0, "R6 read past end is zero");
  endtask

  task automatic testSingleWrite();
    setPtr(8'h03);
    writeByte(8'h5C);
    setPtr(8'h03);
    readCheck(1'b0, "R3 written value");
    readCheck(1'b0, "R4 plain read keeps pointer");
    readCheck(1'b1, "R5 stepping read");
    readCheck(1'b0, "R5 pointer advanced to next register");
    sendByte(8'h27);
    sendByte(8'h39);
    setPtr(8'h05);
    readCheck(1'b0, "R3 write stepped pointer to register 5");
  endtask

  task automatic testPtrHalves();
    setPtr(8'h0A);
    writeByte(8'h77);
    sendByte(8'h05);
    readCheck(1'b0, "R2 low half load keeps high half");
    sendByte(8'h11);
    readCheck(1'b0, "R6 pointer 0x15 reads zero");
    writeByte(8'hFF);
    sendByte(8'h10);
    sendByte(8'h05);
    readCheck(1'b0, "R6 out-of-range write discarded");
    sendByte(8'h0A);
    readCheck(1'b0, "R2 high half reload");
  endtask

  task automatic testBurst();
    logic [23:0] valA;
    logic [23:0] valB;
    logic [7:0]  got;
    logic [23:0] rdA;
    logic [23:0] rdB;
    valA = 24'h123456;
    valB = 24'hABCDEF;
    setPtr(8'h08);
    for (int i = 0; i < 3; i++) writeByte(valA[8*i +: 8]);
    for (int i = 0; i < 3; i++) writeByte(valB[8*i +: 8]);
    setPtr(8'h08);
    rdA = '0;
    rdB = '0;
    for (int i = 0; i < 3; i++) begin
      sendByte(8'h50);
      getByte(got);
      rdA[8*i +: 8] = got;
    end
    for (int i = 0; i < 3; i++) begin
      sendByte(8'h50);
      getByte(got);
      rdB[8*i +: 8] = got;
    end
    checkEq("R9 first value", {8'h0, rdA}, {8'h0, valA});
    checkEq("R9 second value", {8'h0, rdB}, {8'h0, valB});
    readCheck(1'b0, "R5 pointer after six stepping reads");
  endtask

  task automatic testWrap();
    setPtr(8'hFF);
    writeByte(8'h99);
    checkEq("R3 pointer wrapped", {24'h0, mPtr}, 32'h0);
    readCheck(1'b0, "R3 wrap reaches register 0");
    setPtr(8'h00);
    readCheck(1'b0, "R6 wrap write did not alias");
  endtask

  task automatic testIgnored();
    setPtr(8'h02);
    sendByte(8'h25);
    for (int c = 6; c < 16; c++) begin
      sendByte({c[3:0], 4'h9});
      checkEq("R7 no output on ignored code", {31'h0, outValid}, 32'h0);
    end
    sendByte(8'h3A);
    setPtr(8'h02);
    readCheck(1'b0, "R7 latch and pointer kept");
  endtask

  task automatic testStall();
    logic [7:0] exp;
    logic [7:0] held;
    setPtr(8'h06);
    exp = modelRead();
    sendByte(8'h40);
    held = outByte;
    checkEq("R4 read byte", {24'h0, held}, {24'h0, exp});
    inByte  = 8'h2E;
    inValid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      checkEq("R8 input stalled", {31'h0, inReady}, 32'h0);
      checkEq("R8 byte held", {23'h0, outValid, outByte}, {23'h0, 1'b1, held});
    end
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
    checkEq("R8 valid dropped after take", {31'h0, outValid}, 32'h0);
    @(negedge clk);
    inValid = 1'b0;
    modelApply(8'h2E);
    sendByte(8'h31);
    setPtr(8'h06);
    readCheck(1'b0, "R8 stalled write landed once");
  endtask

  initial begin
    testReset();
    testSingleWrite();
    testPtrHalves();
    testBurst();
    testWrap();
    testIgnored();
    testStall();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end
endmodule